// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is the integer arithmetic and logic unit of a 32-bit load/store datapath. It takes two operands and a 4-bit operation code and produces a result word, a carry flag and a signed-overflow flag. It handles signed and unsigned addition and subtraction, the four bitwise operations AND, OR, XOR and NOR, and signed and unsigned less-than comparison.

The datapath is a chain of one-bit slices. Each slice holds a full adder, an optional inverter on the B operand, and a small multiplexer that chooses among the sum, AND, OR and XOR outputs. A decoder turns the operation code into the invert, carry-in and select controls that all slices share. A finishing stage at the top end of the chain forms the overflow flag, the comparison bit and the NOR inversion. The outputs pass through a register, so a result is ready one clock after its operands are presented.

Top module: `bitslice_alu`

## Requirements
- R1: Codes 0000 (signed add) and 0001 (unsigned add) give result = A + B modulo 2^32, and carry_out = bit 32 of the full sum.
- R2: Codes 0010 (signed subtract) and 0011 (unsigned subtract) give result = A + ~B + 1 modulo 2^32, and carry_out = bit 32 of that sum, which is 1 exactly when A >= B unsigned.
- R3: In codes 0000 and 0010, overflow is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. For addition, this is when two operands of equal sign give a result of the other sign.
- R4: A signed add of operands with different sign bits never raises overflow.
- R5: The unsigned codes 0001 and 0011 never raise overflow, and they still drive carry_out.
- R6: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, A XOR B and NOT(A OR B). carry_out and overflow are 0.
- R7: Code 1010 puts 1 in result bit 0 when A < B as two's-complement numbers. Code 1011 does the same for an unsigned compare. Result bits 31..1 are 0.
- R8: The comparison codes 1010 and 1011 drive carry_out and overflow to 0, including when the internal subtraction overflows.
- R9: Codes 1000, 1001 and 1100 through 1111 give result 0, carry_out 0 and overflow 0.
- R10: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R11: While rst is high at a rising edge, result, carry_out and overflow are cleared to 0, whatever the operands and code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Operation code |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| result | output | 32 | Registered result word |
| carry_out | output | 1 | Registered carry from the top slice (add and subtract codes only) |
| overflow | output | 1 | Registered signed-overflow flag |

## Verification
Every output of this block comes out one rising edge after its operands and code: the carry chain settles within the cycle, and the output register is the only storage. The bench changes inputs on the falling edge and samples on the next falling edge, which is one full register stage later. One directed step also samples just after a change to show the outputs still hold the earlier value. The embedded assertions compare each output with the inputs captured one cycle before. They skip the first cycle after reset.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_ADD  = 4'b0000,
    M_ADDU = 4'b0001,
    M_SUB  = 4'b0010,
    M_SUBU = 4'b0011,
    M_AND  = 4'b0100,
    M_OR   = 4'b0101,
    M_XOR  = 4'b0110,
    M_NOR  = 4'b0111,
    M_SLT  = 4'b1010,
    M_SLTU = 4'b1011
  } alu_mode_e;

  typedef enum logic [1:0] {
    SEL_SUM = 2'd0,
    SEL_AND = 2'd1,
    SEL_OR  = 2'd2,
    SEL_XOR = 2'd3
  } slice_sel_e;

  typedef struct packed {
    logic       inv_b;     // feed ~B into the adders
    logic       carry_in;  // carry into slice 0
    slice_sel_e sel;       // per-slice output choice
    logic       inv_out;   // invert the word (NOR)
    logic       arith;     // carry_out is meaningful
    logic       ovf_en;    // signed overflow reported
    logic       cmp_en;    // less-than result
    logic       cmp_uns;   // unsigned compare
    logic       zero;      // unused code
  } alu_ctl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output alu_ctl_t          ctl
);

  always_comb begin
    ctl          = '0;
    ctl.sel      = SEL_SUM;
    case (mode)
      M_ADD:  begin ctl.arith = 1'b1; ctl.ovf_en = 1'b1; end
      M_ADDU: begin ctl.arith = 1'b1; end
      M_SUB:  begin ctl.arith = 1'b1; ctl.ovf_en = 1'b1;
                    ctl.inv_b = 1'b1; ctl.carry_in = 1'b1; end
      M_SUBU: begin ctl.arith = 1'b1;
                    ctl.inv_b = 1'b1; ctl.carry_in = 1'b1; end
      M_AND:  ctl.sel = SEL_AND;
      M_OR:   ctl.sel = SEL_OR;
      M_XOR:  ctl.sel = SEL_XOR;
      M_NOR:  begin ctl.sel = SEL_OR; ctl.inv_out = 1'b1; end
      M_SLT:  begin ctl.cmp_en = 1'b1;
                    ctl.inv_b = 1'b1; ctl.carry_in = 1'b1; end
      M_SLTU: begin ctl.cmp_en = 1'b1; ctl.cmp_uns = 1'b1;
                    ctl.inv_b = 1'b1; ctl.carry_in = 1'b1; end
      default: ctl.zero = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       inv_b,
  input  logic       cin,
  input  slice_sel_e sel,
  output logic       res,
  output logic       cout
);

  logic bb;
  logic prop;
  logic sum;

  assign bb   = b ^ inv_b;
  assign prop = a ^ bb;
  assign sum  = prop ^ cin;
  assign cout = (a & bb) | (cin & prop);

  always_comb begin
    case (sel)
      SEL_SUM: res = sum;
      SEL_AND: res = a & bb;
      SEL_OR:  res = a | bb;
      default: res = prop;
    endcase
  end

endmodule

// File: rtl/alu_finish.sv
module alu_finish
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_ctl_t         ctl,
  input  logic [WIDTH-1:0] raw,
  input  logic             c_into_msb,
  input  logic             c_out_msb,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);

  logic ovf_raw;
  logic less;

  assign ovf_raw = c_into_msb ^ c_out_msb;
  // signed: sign of difference corrected by overflow; unsigned: borrow
  assign less    = ctl.cmp_uns ? ~c_out_msb : (raw[WIDTH-1] ^ ovf_raw);

  always_comb begin
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    if (ctl.zero) begin
      res = '0;
    end else if (ctl.cmp_en) begin
      res[0] = less;
    end else begin
      res   = ctl.inv_out ? ~raw : raw;
      carry = ctl.arith  & c_out_msb;
      ovf   = ctl.ovf_en & ovf_raw;
    end
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out,
  output logic              overflow
);

  localparam int MSB = WIDTH - 1;

  alu_ctl_t         ctl;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] raw;
  logic [WIDTH-1:0] res_d;
  logic             carry_d;
  logic             ovf_d;

  alu_ctrl u_ctrl (
    .mode (mode),
    .ctl  (ctl)
  );

  assign chain[0] = ctl.carry_in;

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    alu_slice u_slice (
      .a     (op_a[g]),
      .b     (op_b[g]),
      .inv_b (ctl.inv_b),
      .cin   (chain[g]),
      .sel   (ctl.sel),
      .res   (raw[g]),
      .cout  (chain[g+1])
    );
  end

  alu_finish #(.WIDTH(WIDTH)) u_finish (
    .ctl        (ctl),
    .raw        (raw),
    .c_into_msb (chain[MSB]),
    .c_out_msb  (chain[WIDTH]),
    .res        (res_d),
    .carry      (carry_d),
    .ovf        (ovf_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      result    <= res_d;
      carry_out <= carry_d;
      overflow  <= ovf_d;
    end
  end

  // R1: registered add equals the operand sum of the previous cycle
  a_r1_add_sum: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == M_ADD || $past(mode) == M_ADDU))
      |-> result == $past(op_a) + $past(op_b));

  // R3: signed add of equal-sign operands flags a sign flip
  a_r3_ovf_sign_flip: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_ADD && $past(op_a[MSB]) == $past(op_b[MSB]))
      |-> overflow == (result[MSB] != $past(op_a[MSB])));

  // R4: opposite-sign addition never overflows
  a_r4_no_ovf_mixed_sign: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_ADD && $past(op_a[MSB]) != $past(op_b[MSB]))
      |-> !overflow);

  // R5: unsigned arithmetic never reports overflow
  a_r5_unsigned_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == M_ADDU || $past(mode) == M_SUBU))
      |-> !overflow);

  // R7 / R8: compare results occupy only bit 0 and clear both flags
  a_r7_cmp_single_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == M_SLT || $past(mode) == M_SLTU))
      |-> (result[MSB:1] == '0 && !carry_out && !overflow));

  // R6: bitwise codes clear carry and overflow
  a_r6_logic_no_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode[3:2]) == 2'b01)
      |-> (!carry_out && !overflow));

  // R9: codes outside the table give all zeros
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode[3:1]) == 3'b100 || $past(mode[3:2]) == 2'b11))
      |-> (result == '0 && !carry_out && !overflow));

  // R11: a reset cycle leaves cleared outputs
  a_r11_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !carry_out && !overflow));

endmodule

// File: tb/test_bitslice_alu.sv
`timescale 1ns/1ps
module test_bitslice_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode = 4'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] result;
  logic        carry_out;
  logic        overflow;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  bitslice_alu #(.WIDTH(32)) i_bitslice_alu (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        c;
    logic        v;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1}, // R3
    '{4'b0001, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0}, // R5
    '{4'b0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0}, // R4
    '{4'b0010, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 1'b1}, // R2 R3
    '{4'b0011, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R2 R5
    '{4'b0100, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0, 1'b0}, // R6
    '{4'b0101, 32'hF000_000F, 32'h0000_F0F0, 32'hF000_F0FF, 1'b0, 1'b0}, // R6
    '{4'b0110, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F, 1'b0, 1'b0}, // R6
    '{4'b0111, 32'h0000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 1'b0, 1'b0}, // R6
    '{4'b1010, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}, // R7
    '{4'b1011, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0, 1'b0}, // R7
    '{4'b1010, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0}, // R8
    '{4'b1011, 32'h0000_0001, 32'h0000_0002, 32'h0000_0001, 1'b0, 1'b0}, // R7
    '{4'b1100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0}, // R9
    '{4'b1010, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 1'b0}, // R7
    '{4'b0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1}  // R1 R3
  };

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'b0000, 4'b0001: return "R1";
      4'b0010, 4'b0011: return "R2";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R6";
      4'b1010, 4'b1011: return "R7";
      default: return "R9";
    endcase
  endfunction

  // independent model: {result, carry, overflow}
  function automatic logic [33:0] model(input logic [3:0] m,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    logic [32:0] s;
    logic [31:0] r;
    logic        c;
    logic        v;
    r = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'b0000, 4'b0001: begin
        s = {1'b0, a} + {1'b0, b};
        r = s[31:0]; c = s[32];
        v = (m == 4'b0000) && (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'b0010, 4'b0011: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = s[31:0]; c = s[32];
        v = (m == 4'b0010) && (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'b0100: r = a & b;
      4'b0101: r = a | b;
      4'b0110: r = a ^ b;
      4'b0111: r = ~(a | b);
      4'b1010: r = {31'b0, ($signed(a) < $signed(b))};
      4'b1011: r = {31'b0, (a < b)};
      default: r = '0;
    endcase
    return {r, c, v};
  endfunction

  task automatic check(input string req, input logic [31:0] er,
                       input logic ec, input logic ev);
    checks++;
    if (result !== er || carry_out !== ec || overflow !== ev) begin
      errors++;
      $display("FAIL %s mode=%b a=%h b=%h got r=%h c=%b v=%b exp r=%h c=%b v=%b",
               req, mode, op_a, op_b, result, carry_out, overflow, er, ec, ev);
    end
  endtask

  task automatic apply(input logic [3:0] m, input logic [31:0] a,
                       input logic [31:0] b);
    @(negedge clk);
    mode = m; op_a = a; op_b = b;
    @(negedge clk);   // one register stage later
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    logic [33:0] e;
    // R11: reset state with live inputs
    mode = 4'b0000; op_a = 32'h7FFF_FFFF; op_b = 32'h1;
    repeat (3) @(negedge clk);
    check("R11", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // R10: output holds until the next rising edge
    @(negedge clk);
    check("R1", 32'h8000_0000, 1'b0, 1'b1);
    mode = 4'b0000; op_a = 32'd3; op_b = 32'd4;
    #1 check("R10", 32'h8000_0000, 1'b0, 1'b1);
    @(negedge clk);
    check("R10", 32'd7, 1'b0, 1'b0);

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].m, VEC[i].a, VEC[i].b);
      check(req_of(VEC[i].m), VEC[i].r, VEC[i].c, VEC[i].v);
    end

    // R9: every unused code
    for (int u = 0; u < 16; u++) begin
      if (u == 8 || u == 9 || u >= 12) begin
        apply(4'(u), 32'h8000_0000, 32'h8000_0000);
        check("R9", 32'h0, 1'b0, 1'b0);
      end
    end

    // R8: compare whose internal subtract overflows
    apply(4'b1010, 32'h8000_0000, 32'h0000_0001);
    check("R8", 32'h1, 1'b0, 1'b0);

    // R5: unsigned subtract with borrow-free wrap
    apply(4'b0011, 32'h8000_0000, 32'h0000_0001);
    check("R5", 32'h7FFF_FFFF, 1'b1, 1'b0);

    // R4: opposite signs, extreme magnitudes
    apply(4'b0000, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R4", 32'hFFFF_FFFF, 1'b0, 1'b0);

    // random and corner mix over all codes
    for (int k = 0; k < 800; k++) begin
      logic [3:0]  m;
      logic [31:0] a;
      logic [31:0] b;
      m = 4'($urandom % 16);
      a = pick();
      b = pick();
      apply(m, a, b);
      e = model(m, a, b);
      check(req_of(m), e[33:2], e[1], e[0]);
    end

    // R11: synchronous reset mid-run
    @(negedge clk);
    mode = 4'b0010; op_a = 32'h8000_0000; op_b = 32'h1;
    rst = 1'b1;
    @(negedge clk);
    check("R11", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R3", 32'h7FFF_FFFF, 1'b1, 1'b1);

    finish_run();
  end

endmodule